// File: doc/BRIEF.md
# Pin Interrupt Trigger Detector Bank

This block watches a set of already debounced pin levels and turns each one into a latched interrupt and a latched wake indication. Each pin has its own control word. The word selects edge or level sensitivity and holds a two-bit polarity code: low/falling, high/rising, both edges, or reserved. It also holds an enable bit, a delivery (unmask) bit, one wake enable for each of three sleep states, and the pad direction and drive value. Status bits are sticky, and software clears them by writing one to them.

A host writes one pin's word through a single-cycle write port. It reads any pin's word, together with the live pin level and both status bits, through a combinational read port. Each pin drives a pending line toward an interrupt aggregator. The enable bit gates detection, so no interrupt status is latched while it is clear. The unmask bit gates only delivery, so status can collect while the pin is masked and is delivered once it is unmasked. The current power state chooses which of the wake enables applies.

Top module: `irq_trig_bank`

## Requirements
- R1: After reset every control word, interrupt status and wake status is zero, the previous-level register is low, and all of irq_pend_o, pad_oe_o and pad_out_o are 0.
- R2: With bit0 (level mode) = 0 and bit3 (enable) = 1, code bits[2:1] = 01 latches interrupt status (read bit11) on a low-to-high change of the pin. Code 00 latches it on a high-to-low change, and code 10 on either change. The status is visible after the clock edge that samples the new level.
- R3: Code 11 never latches interrupt or wake status, in either mode. In level mode, code 10 also never triggers.
- R4: With level mode = 1, code 01 latches status on every cycle the pin is high, and code 00 on every cycle it is low. A clear written while the level is active leaves the status set.
- R5: With enable bit3 = 0, no event latches interrupt status.
- R6: irq_pend_o of a pin = (interrupt status AND enable AND unmask bit4) OR wake status. Status still latches while bit4 = 0.
- R7: A write loads bits[9:0] of the word. A 1 in bit11 clears interrupt status and a 1 in bit12 clears wake status. A 0 in either bit leaves that status unchanged.
- R8: If a clear and a new event fall in the same cycle, the status ends up set.
- R9: pwr_state_i = 0 is the running state, and no wake status latches in it. For a value k in 1..3, a trigger event latches wake status (read bit12) only if wake enable bit (4+k) is 1. This does not depend on the interrupt enable bit.
- R10: Read bit10 shows the current pin level of the selected pin. Bits[9:0] read back the stored word.
- R11: pad_oe_o follows bit8 and pad_out_o follows bit9 of each pin's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_level_i | input | NUM_PINS | Debounced pin levels |
| pwr_state_i | input | 2 | 0 running, 1..3 sleep state |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | SEL_W | Pin selected for write |
| wr_data_i | input | 13 | Control word / clear bits |
| rd_sel_i | input | SEL_W | Pin selected for read |
| rd_data_o | output | 13 | Word, pin level, status bits |
| irq_pend_o | output | NUM_PINS | Pending line per pin |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_out_o | output | NUM_PINS | Pad output value |

## Verification
A wrong previous-level register or a wrong polarity decode shows up as a wrong bit11 and a wrong pending line one clock after the pin changes. The bench sweeps every code, mode and pair of levels, so a single fault is exposed within the sweep. A wrong clear priority, enable gate or wake gate leaves a status bit set or clear that should not be. That error is visible on the very next read and on irq_pend_o, and it persists because the status is sticky.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int SLEEP_STATES = 3;
  localparam int PWR_W        = $clog2(SLEEP_STATES + 1);
  localparam int CFG_W        = 10;
  localparam int LVL_BIT      = CFG_W;
  localparam int INT_STS_BIT  = CFG_W + 1;
  localparam int WAKE_STS_BIT = CFG_W + 2;
  localparam int REG_W        = CFG_W + 3;

  typedef enum logic [1:0] {
    ACT_LOW  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;

  typedef struct packed {
    logic                    out_val;
    logic                    out_en;
    logic [SLEEP_STATES-1:0] wake_en;
    logic                    unmask;
    logic                    int_en;
    act_e                    code;
    logic                    lvl_mode;
  } cfg_t;
endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect
  import irq_trig_pkg::*;
(
  input  logic cur_i,
  input  logic prev_i,
  input  logic lvl_mode_i,
  input  act_e code_i,
  output logic evt_o
);
  always_comb begin
    unique case (code_i)
      ACT_LOW:  evt_o = lvl_mode_i ? ~cur_i : (prev_i & ~cur_i);
      ACT_HIGH: evt_o = lvl_mode_i ?  cur_i : (cur_i & ~prev_i);
      ACT_BOTH: evt_o = lvl_mode_i ? 1'b0   : (cur_i ^ prev_i);
      default:  evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_wake_gate.sv
module irq_wake_gate
  import irq_trig_pkg::*;
(
  input  logic [PWR_W-1:0]        pwr_state_i,
  input  logic [SLEEP_STATES-1:0] wake_en_i,
  output logic                    wake_ok_o
);
  always_comb begin
    wake_ok_o = 1'b0;
    for (int k = 0; k < SLEEP_STATES; k++) begin
      if (pwr_state_i == PWR_W'(k + 1)) wake_ok_o = wake_en_i[k];
    end
  end
endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_trig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic [PWR_W-1:0] pwr_state_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output cfg_t             cfg_o,
  output logic             int_sts_o,
  output logic             wake_sts_o,
  output logic             evt_o,
  output logic             pend_o
);
  cfg_t cfg_q;
  logic prev_q, int_q, wake_q;
  logic evt, wake_ok, clr_int, clr_wake;

  irq_evt_detect u_det (
    .cur_i      (level_i),
    .prev_i     (prev_q),
    .lvl_mode_i (cfg_q.lvl_mode),
    .code_i     (cfg_q.code),
    .evt_o      (evt)
  );

  irq_wake_gate u_wake (
    .pwr_state_i (pwr_state_i),
    .wake_en_i   (cfg_q.wake_en),
    .wake_ok_o   (wake_ok)
  );

  assign clr_int  = wr_i & wr_data_i[INT_STS_BIT];
  assign clr_wake = wr_i & wr_data_i[WAKE_STS_BIT];

  // set term sits outside the clear mask: a same-cycle event wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      int_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (wr_i) cfg_q <= cfg_t'(wr_data_i[CFG_W-1:0]);
      int_q  <= (evt & cfg_q.int_en) | (int_q & ~clr_int);
      wake_q <= (evt & wake_ok) | (wake_q & ~clr_wake);
    end
  end

  assign cfg_o      = cfg_q;
  assign int_sts_o  = int_q;
  assign wake_sts_o = wake_q;
  assign evt_o      = evt;
  assign pend_o     = (int_q & cfg_q.int_en & cfg_q.unmask) | wake_q;
endmodule

// File: rtl/irq_trig_bank.sv
module irq_trig_bank
  import irq_trig_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_level_i,
  input  logic [PWR_W-1:0]    pwr_state_i,
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic [SEL_W-1:0]    rd_sel_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic [NUM_PINS-1:0] irq_pend_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o
);
  cfg_t                  cfg_v [NUM_PINS];
  logic [NUM_PINS-1:0]   int_sts_v, wake_sts_v, evt_v, int_en_v;
  logic [2*NUM_PINS-1:0] act_code_v;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    irq_pin_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .level_i     (pin_level_i[i]),
      .pwr_state_i (pwr_state_i),
      .wr_i        (wr_en_i && (wr_sel_i == SEL_W'(i))),
      .wr_data_i   (wr_data_i),
      .cfg_o       (cfg_v[i]),
      .int_sts_o   (int_sts_v[i]),
      .wake_sts_o  (wake_sts_v[i]),
      .evt_o       (evt_v[i]),
      .pend_o      (irq_pend_o[i])
    );
    assign pad_oe_o[i]          = cfg_v[i].out_en;
    assign pad_out_o[i]         = cfg_v[i].out_val;
    assign int_en_v[i]          = cfg_v[i].int_en;
    assign act_code_v[2*i +: 2] = cfg_v[i].code;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rd_sel_i == SEL_W'(i))
        rd_data_o = {wake_sts_v[i], int_sts_v[i], pin_level_i[i], cfg_v[i]};
    end
  end
endmodule

// File: rtl/irq_trig_chk.sv
module irq_trig_chk
  import irq_trig_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [PWR_W-1:0]      pwr_state_i,
  input logic [NUM_PINS-1:0]   irq_pend_o,
  input logic [NUM_PINS-1:0]   int_sts_v,
  input logic [NUM_PINS-1:0]   wake_sts_v,
  input logic [NUM_PINS-1:0]   int_en_v,
  input logic [NUM_PINS-1:0]   evt_v,
  input logic [2*NUM_PINS-1:0] act_code_v
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    a_r6_pend_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_pend_o[i] |-> (int_sts_v[i] || wake_sts_v[i]));
    a_r3_reserved_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_sts_v[i]) |-> ($past(act_code_v[2*i +: 2]) != 2'b11));
    a_r5_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_sts_v[i]) |-> $past(int_en_v[i]));
    a_r8_event_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_v[i] && int_en_v[i]) |=> int_sts_v[i]);
    a_r9_running_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wake_sts_v[i]) |-> ($past(pwr_state_i) != '0));
  end
endmodule

bind irq_trig_bank irq_trig_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_state_i (pwr_state_i),
  .irq_pend_o  (irq_pend_o),
  .int_sts_v   (int_sts_v),
  .wake_sts_v  (wake_sts_v),
  .int_en_v    (int_en_v),
  .evt_v       (evt_v),
  .act_code_v  (act_code_v)
);

// File: tb/irq_trig_bank_tb_top.sv
module irq_trig_bank_tb_top;
  localparam int N = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pin_lvl = '0;
  logic [1:0]    pwr = '0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_sel = '0;
  logic [12:0]   wr_data = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [12:0]   rd_data;
  logic [N-1:0]  pend, oe, ov;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_trig_bank #(.NUM_PINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pin_level_i(pin_lvl), .pwr_state_i(pwr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .irq_pend_o(pend), .pad_oe_o(oe), .pad_out_o(ov)
  );

  function automatic logic [12:0] mk(int code, int lvl, int en, int um, int wk, int oen, int oval);
    logic [12:0] w = '0;
    w[0] = lvl[0]; w[2:1] = code[1:0]; w[3] = en[0]; w[4] = um[0];
    w[7:5] = wk[2:0]; w[8] = oen[0]; w[9] = oval[0];
    return w;
  endfunction

  function automatic logic exp_ev(int code, int lvl, logic cur, logic prv);
    if (code == 3) return 1'b0;
    if (lvl != 0) return (code == 0) ? ~cur : (code == 1) ? cur : 1'b0;
    return (code == 0) ? (prv & ~cur) : (code == 1) ? (cur & ~prv) : (cur ^ prv);
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int p, logic [12:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SW'(p); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int p, output logic [12:0] v);
    rd_sel = SW'(p);
    #1 v = rd_data;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [12:0] v;
    logic [12:0] c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int p = 0; p < N; p++) begin
      rd(p, v);
      chk({19'd0, v}, 32'd0, "R1 reset word");
    end
    chk({pend, oe, ov}, 0, "R1 reset outputs");

    // R2 R3 R4: sweep code x mode x level pair on pin 0
    for (int code = 0; code < 4; code++)
      for (int lvl = 0; lvl < 2; lvl++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++) begin
            logic e;
            c = mk(code, lvl, 1, 1, 0, 0, 0);
            pin_lvl[0] = a[0];
            wr(0, c);
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 0; wr_data = c | 13'h800;
            @(negedge clk);
            wr_en = 1'b0; pin_lvl[0] = b[0];
            @(negedge clk);
            e = exp_ev(code, lvl, a[0], a[0]) | exp_ev(code, lvl, b[0], a[0]);
            rd(0, v);
            chk(v[11], e, (code == 3) ? "R3 reserved code" : (lvl != 0) ? "R4 level sweep" : "R2 edge sweep");
            chk(pend[0], e, "R6 pend follows status in sweep");
          end
    wr(0, 13'h800 | mk(0, 0, 0, 0, 0, 0, 0));

    // R4 clear during active level keeps status
    pin_lvl[0] = 1'b1;
    wr(0, mk(1, 1, 1, 1, 0, 0, 0));
    wr(0, mk(1, 1, 1, 1, 0, 0, 0) | 13'h800);
    rd(0, v);
    chk(v[11], 1, "R4 clear while active");
    pin_lvl[0] = 1'b0;
    @(negedge clk);
    wr(0, mk(1, 1, 1, 1, 0, 0, 0) | 13'h800);
    rd(0, v);
    chk(v[11], 0, "R4 clear after inactive");

    // R5 disabled pin ignores edges
    pin_lvl[2] = 1'b0;
    wr(2, mk(1, 0, 0, 1, 0, 0, 0));
    pin_lvl[2] = 1'b1;
    @(negedge clk);
    rd(2, v);
    chk({v[11], pend[2]}, 0, "R5 enable off");

    // R6 masked status latches, delivered on unmask
    pin_lvl[1] = 1'b0;
    wr(1, mk(1, 0, 1, 0, 0, 0, 0));
    pin_lvl[1] = 1'b1;
    @(negedge clk);
    rd(1, v);
    chk({v[11], pend[1]}, 2'b10, "R6 masked");
    wr(1, mk(1, 0, 1, 1, 0, 0, 0));
    chk(pend[1], 1, "R6 unmasked");
    // R7 zero in clear bit keeps status, one clears
    wr(1, mk(1, 0, 1, 1, 0, 0, 0));
    rd(1, v);
    chk(v[11], 1, "R7 no clear");
    // R8 clear and rising edge together
    pin_lvl[1] = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1; wr_data = mk(1, 0, 1, 1, 0, 0, 0) | 13'h800;
    pin_lvl[1] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(1, v);
    chk(v[11], 1, "R8 event wins");
    wr(1, mk(1, 0, 1, 1, 0, 0, 0) | 13'h800);
    rd(1, v);
    chk({v[11], pend[1]}, 0, "R7 clear");

    // R9 wake gating by power state
    pin_lvl[3] = 1'b0;
    for (int s = 0; s < 4; s++) begin
      pwr = 2'(s);
      wr(3, mk(1, 0, 0, 0, 2, 0, 0) | 13'h1000);
      pin_lvl[3] = 1'b1;
      @(negedge clk);
      rd(3, v);
      chk({v[12], pend[3]}, (s == 2) ? 2'b11 : 2'b00, "R9 wake gate");
      pin_lvl[3] = 1'b0;
      @(negedge clk);
    end
    pwr = 2'd3;
    wr(3, mk(2, 0, 0, 0, 4, 0, 0) | 13'h1000);
    pin_lvl[3] = 1'b1;
    @(negedge clk);
    rd(3, v);
    chk({v[12], v[11]}, 2'b10, "R9 wake both edges, int off");
    wr(3, mk(2, 0, 0, 0, 4, 0, 0) | 13'h1000);
    rd(3, v);
    chk(v[12], 0, "R7 wake clear");
    pwr = 2'd0;

    // R10 readback of word and live level
    for (int p = 0; p < N; p++) begin
      pin_lvl = 4'b0101;
      wr(p, mk(p % 4, 0, 0, 0, p, 0, 0));
      rd(p, v);
      chk({v[10], v[9:0]}, {p % 2 == 0, mk(p % 4, 0, 0, 0, p, 0, 0)[9:0]}, "R10 readback");
    end

    // R11 pad controls
    for (int k = 0; k < 4; k++) begin
      wr(1, mk(0, 0, 0, 0, 0, k % 2, k / 2));
      chk({oe[1], ov[1]}, {1'(k % 2), 1'(k / 2)}, "R11 pad bits");
    end

    summary();
    $finish;
  end
endmodule